// File: doc/BRIEF.md
# Dual-Rate Waveform Capture Buffer

This block sits beside a digital regulation loop and records one of its signals (reference, feedback or error) for monitoring and for analysis after a fault. A full-rate sample stream arrives with a valid strobe at the loop rate of 100 kHz. The block keeps one of every `DECIM` valid samples (20 by default, which gives 5 kHz). It pushes each kept sample into a small first-in first-out queue, and a consumer drains the queue with a pop strobe. This stream never stops.

Alongside that stream, a single-shot capture engine records a full-rate burst. Software arms the engine. The first trigger seen while armed starts the capture. The next `BURST_LEN` valid samples are written into a local memory, and the engine then freezes in a done state until software arms it again. The frozen burst is read through a synchronous read port. Triggers that arrive when the engine is not waiting for one are counted in a saturating counter, so software can tell that events were lost. A clear strobe restarts the low-rate stream and its error flags. It leaves the burst engine alone.

Top module: `wcap_top`

## Requirements
- R1: After reset, `bst_state` is 0 (idle), `lr_valid` is 0, `lr_ovf` is 0 and `miss_cnt` is 0.
- R2: Counting valid samples from reset or from the last `clr`, the samples numbered 0, DECIM, 2·DECIM and so on enter the low-rate queue, and no other sample does. Cycles without `smp_valid` do not advance the count.
- R3: The low-rate queue is first-in first-out and show-ahead. `lr_data` holds the oldest entry whenever `lr_valid` is 1, and a cycle with `lr_pop` high and `lr_valid` high removes that entry.
- R4: If the queue already holds `LR_DEPTH` entries when a sample is due, that sample is dropped and `lr_ovf` rises. `lr_ovf` stays at 1 through pops until `clr`.
- R5: `clr` empties the queue, restarts the sample count of R2, and clears `lr_ovf` and `miss_cnt`. It does not change `bst_state` or the burst memory.
- R6: `arm` moves the engine to armed (state 1) from idle, armed or done. `arm` has no effect while capturing (state 2).
- R7: A trigger while armed moves the engine to capturing (state 2) on the next cycle. The next `BURST_LEN` valid samples are stored at addresses 0 to `BURST_LEN`-1 in arrival order, and the engine then enters done (state 3).
- R8: In done, the burst memory is frozen against further samples and the state stays 3 until `arm`.
- R9: A trigger in idle, capturing or done changes no state and adds 1 to `miss_cnt`. The counter saturates at 2^`MISS_W`-1.
- R10: The low-rate stream keeps running, as in R2, while a burst is captured and while it is frozen.
- R11: `bst_rd_data` shows the burst word at the address that `bst_rd_addr` held on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Full-rate sample strobe |
| smp_data | input | DATA_W | Full-rate sample value |
| trig | input | 1 | Single-shot capture trigger |
| arm | input | 1 | Arm or re-arm the burst engine |
| clr | input | 1 | Restart the low-rate stream and clear its flags |
| lr_pop | input | 1 | Remove the oldest low-rate entry |
| lr_valid | output | 1 | Low-rate queue is not empty |
| lr_data | output | DATA_W | Oldest low-rate entry |
| lr_ovf | output | 1 | Sticky low-rate overflow flag |
| bst_state | output | 2 | Burst state: 0 idle, 1 armed, 2 capturing, 3 done |
| bst_rd_addr | input | $clog2(BURST_LEN) | Burst memory read address |
| bst_rd_data | output | DATA_W | Burst word, one cycle after the address |
| miss_cnt | output | MISS_W | Saturating count of ignored triggers |

## Verification
A wrong decimation phase shows up at the first pop: the queued value is off by a multiple of the sample step, so it appears within one decimation period. A burst engine that leaves done by itself, or that writes while frozen, shows in `bst_state` on the next cycle, or in read-back words that no longer match the captured run. A missed-trigger counter that wraps instead of saturating shows as a small value after a long run of ignored triggers. An overflow flag that is not sticky drops to 0 on the first pop after the overflow.

// File: rtl/wcap_pkg.sv
package wcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARMED = 2'd1,
        ST_CAPT = 2'd2,
        ST_DONE = 2'd3
    } cap_state_e;

    typedef struct packed {
        logic arm;
        logic trig;
        logic clr;
    } cap_ctl_t;

endpackage

// File: rtl/wcap_decim.sv
module wcap_decim #(
    parameter int DATA_W = 24,
    parameter int DECIM  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int CW = (DECIM > 1) ? $clog2(DECIM) : 1;

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (in_valid) begin
            if (phase_q == CW'(DECIM - 1)) phase_q <= '0;
            else                           phase_q <= phase_q + 1'b1;
        end
    end

    assign out_valid = in_valid && (phase_q == '0);
    assign out_data  = in_data;
endmodule

// File: rtl/wcap_fifo.sv
module wcap_fifo #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              not_empty,
    output logic [DATA_W-1:0] head_data,
    output logic              ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = AW + 1;

    logic [DATA_W-1:0] store [DEPTH];
    logic [AW-1:0]     wr_q, rd_q;
    logic [NW-1:0]     fill_q;
    logic              full, do_push, do_pop;

    assign full      = (fill_q == NW'(DEPTH));
    assign not_empty = (fill_q != '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;
    assign head_data = store[rd_q];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) store[wr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_q   <= '0;
            rd_q   <= '0;
            fill_q <= '0;
        end else begin
            if (do_push) wr_q <= nxt(wr_q);
            if (do_pop)  rd_q <= nxt(rd_q);
            case ({do_push, do_pop})
                2'b10:   fill_q <= fill_q + 1'b1;
                2'b01:   fill_q <= fill_q - 1'b1;
                default: fill_q <= fill_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush)      ovf <= 1'b0;
        else if (push && full) ovf <= 1'b1;
    end
endmodule

// File: rtl/wcap_burst.sv
module wcap_burst
    import wcap_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int BURST_LEN = 64,
    parameter int MISS_W    = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  cap_ctl_t                     ctl,
    input  logic                         in_valid,
    input  logic [DATA_W-1:0]            in_data,
    input  logic [$clog2(BURST_LEN)-1:0] rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    output cap_state_e                   state,
    output logic [MISS_W-1:0]            miss
);
    localparam int AW = $clog2(BURST_LEN);

    logic [DATA_W-1:0] mem [BURST_LEN];
    logic [AW-1:0]     wr_idx;
    logic              wr_en;

    assign wr_en = (state == ST_CAPT) && in_valid;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= in_data;
        rd_data <= mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            wr_idx <= '0;
        end else if (ctl.arm && state != ST_CAPT) begin
            state  <= ST_ARMED;
            wr_idx <= '0;
        end else begin
            unique case (state)
                ST_ARMED: if (ctl.trig) state <= ST_CAPT;
                ST_CAPT: begin
                    if (in_valid) begin
                        if (wr_idx == AW'(BURST_LEN - 1)) begin
                            state  <= ST_DONE;
                            wr_idx <= '0;
                        end else begin
                            wr_idx <= wr_idx + 1'b1;
                        end
                    end
                end
                default: state <= state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            miss <= '0;
        end else if (ctl.trig && state != ST_ARMED && miss != '1) begin
            miss <= miss + 1'b1;
        end
    end
endmodule

// File: rtl/wcap_top.sv
module wcap_top
    import wcap_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int DECIM     = 20,
    parameter int LR_DEPTH  = 16,
    parameter int BURST_LEN = 64,
    parameter int MISS_W    = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         smp_valid,
    input  logic [DATA_W-1:0]            smp_data,
    input  logic                         trig,
    input  logic                         arm,
    input  logic                         clr,
    input  logic                         lr_pop,
    output logic                         lr_valid,
    output logic [DATA_W-1:0]            lr_data,
    output logic                         lr_ovf,
    output logic [1:0]                   bst_state,
    input  logic [$clog2(BURST_LEN)-1:0] bst_rd_addr,
    output logic [DATA_W-1:0]            bst_rd_data,
    output logic [MISS_W-1:0]            miss_cnt
);
    logic              keep_v;
    logic [DATA_W-1:0] keep_d;
    cap_ctl_t          ctl;
    cap_state_e        st;

    assign ctl = '{arm: arm, trig: trig, clr: clr};

    wcap_decim #(.DATA_W(DATA_W), .DECIM(DECIM)) u_decim (
        .clk(clk), .rst(rst), .clr(clr),
        .in_valid(smp_valid), .in_data(smp_data),
        .out_valid(keep_v), .out_data(keep_d)
    );

    wcap_fifo #(.DATA_W(DATA_W), .DEPTH(LR_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .flush(clr),
        .push(keep_v), .push_data(keep_d), .pop(lr_pop),
        .not_empty(lr_valid), .head_data(lr_data), .ovf(lr_ovf)
    );

    wcap_burst #(.DATA_W(DATA_W), .BURST_LEN(BURST_LEN), .MISS_W(MISS_W)) u_burst (
        .clk(clk), .rst(rst), .ctl(ctl),
        .in_valid(smp_valid), .in_data(smp_data),
        .rd_addr(bst_rd_addr), .rd_data(bst_rd_data),
        .state(st), .miss(miss_cnt)
    );

    assign bst_state = st;
endmodule

// File: rtl/wcap_chk.sv
module wcap_chk #(
    parameter int MISS_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              trig,
    input logic              arm,
    input logic              clr,
    input logic              lr_pop,
    input logic              lr_valid,
    input logic              lr_ovf,
    input logic [1:0]        bst_state,
    input logic [MISS_W-1:0] miss_cnt
);
    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (lr_ovf && !clr) |=> lr_ovf);

    // R3
    lr_drain_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lr_valid) |-> ($past(lr_pop) || $past(clr)));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bst_state == 2'd3 && !arm) |=> (bst_state == 2'd3));

    // R7
    armed_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (bst_state == 2'd1 && trig && !arm) |=> (bst_state == 2'd2));

    // R6
    capt_noarm_chk: assert property (@(posedge clk) disable iff (rst)
        (bst_state == 2'd2 && arm) |=> (bst_state != 2'd1));

    // R9
    miss_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (miss_cnt >= $past(miss_cnt)));
endmodule

bind wcap_top wcap_chk #(.MISS_W(MISS_W)) u_chk (
    .clk(clk), .rst(rst), .trig(trig), .arm(arm), .clr(clr),
    .lr_pop(lr_pop), .lr_valid(lr_valid), .lr_ovf(lr_ovf),
    .bst_state(bst_state), .miss_cnt(miss_cnt)
);

// File: tb/tb_wcap_top.sv
`timescale 1ns/1ps
module tb_wcap_top;
    localparam int DW = 24;
    localparam int DEC = 20;
    localparam int DEP = 16;
    localparam int BL = 64;
    localparam int MW = 8;

    logic clk = 0;
    logic rst = 1;
    logic smp_valid = 0;
    logic [DW-1:0] smp_data = '0;
    logic trig = 0, arm = 0, clr = 0, lr_pop = 0;
    logic lr_valid, lr_ovf;
    logic [DW-1:0] lr_data, bst_rd_data;
    logic [1:0] bst_state;
    logic [$clog2(BL)-1:0] bst_rd_addr = '0;
    logic [MW-1:0] miss_cnt;

    int errors = 0;
    int checks = 0;
    int seq = 100;

    always #5 clk = ~clk;

    wcap_top #(.DATA_W(DW), .DECIM(DEC), .LR_DEPTH(DEP), .BURST_LEN(BL), .MISS_W(MW)) dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .trig(trig), .arm(arm), .clr(clr), .lr_pop(lr_pop),
        .lr_valid(lr_valid), .lr_data(lr_data), .lr_ovf(lr_ovf),
        .bst_state(bst_state), .bst_rd_addr(bst_rd_addr),
        .bst_rd_data(bst_rd_data), .miss_cnt(miss_cnt)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic pulse_clr();
        clr = 1; tick(); clr = 0;
    endtask

    task automatic pulse_arm();
        arm = 1; tick(); arm = 0;
    endtask

    task automatic pulse_trig();
        trig = 1; tick(); trig = 0;
    endtask

    task automatic push(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            smp_valid = 1; smp_data = DW'(seq); seq++;
            tick();
            smp_valid = 0;
            if (gaps && (i % 3 == 1)) tick();
        end
        tick();
    endtask

    task automatic pop_expect(input string req, input int val);
        chk({req, " valid"}, lr_valid, 1);
        chk({req, " data"}, lr_data, val);
        lr_pop = 1; tick(); lr_pop = 0;
    endtask

    task automatic rd_expect(input string req, input int addr, input int val);
        bst_rd_addr = addr[$clog2(BL)-1:0];
        tick();
        chk(req, bst_rd_data, val);
    endtask

    task automatic t_reset();
        chk("R1 state", bst_state, 0);
        chk("R1 lr_valid", lr_valid, 0);
        chk("R1 ovf", lr_ovf, 0);
        chk("R1 miss", miss_cnt, 0);
    endtask

    task automatic t_decim();
        int base;
        pulse_clr();
        base = seq;
        push(60, 1);
        pop_expect("R2 first", base);
        pop_expect("R3 second", base + 20);
        pop_expect("R2 third", base + 40);
        chk("R3 empty", lr_valid, 0);
    endtask

    task automatic t_overflow();
        int base;
        pulse_clr();
        base = seq;
        push(DEC * (DEP + 1), 0);
        chk("R4 ovf set", lr_ovf, 1);
        for (int i = 0; i < DEP; i++) pop_expect("R4 kept", base + DEC * i);
        chk("R4 drop", lr_valid, 0);
        chk("R4 sticky", lr_ovf, 1);
        push(1, 0);
        pulse_clr();
        chk("R5 ovf clr", lr_ovf, 0);
        chk("R5 flush", lr_valid, 0);
    endtask

    task automatic t_burst();
        int base, base2;
        pulse_clr();
        chk("R5 miss clr", miss_cnt, 0);
        pulse_trig();
        chk("R9 idle trig state", bst_state, 0);
        chk("R9 idle trig miss", miss_cnt, 1);
        pulse_arm();
        chk("R6 arm from idle", bst_state, 1);
        pulse_trig();
        chk("R7 capturing", bst_state, 2);
        base = seq;
        push(BL + 10, 0);
        chk("R7 done", bst_state, 3);
        pulse_trig();
        chk("R8 done kept", bst_state, 3);
        chk("R9 done trig miss", miss_cnt, 2);
        for (int i = 0; i < BL; i++) rd_expect("R11 R7 R8 burst word", i, base + i);
        pop_expect("R10 stream", base);
        pop_expect("R10 stream", base + 20);
        pop_expect("R10 stream", base + 40);
        pop_expect("R10 stream", base + 60);
        pulse_arm();
        chk("R6 arm from done", bst_state, 1);
        pulse_trig();
        base2 = seq;
        push(3, 0);
        pulse_arm();
        chk("R6 arm in capture", bst_state, 2);
        for (int i = 0; i < 300; i++) pulse_trig();
        chk("R9 saturate", miss_cnt, (1 << MW) - 1);
        chk("R9 capt trig state", bst_state, 2);
        pulse_clr();
        chk("R5 miss clr", miss_cnt, 0);
        chk("R5 state kept", bst_state, 2);
        push(BL - 3, 0);
        chk("R7 done again", bst_state, 3);
        rd_expect("R7 new burst", 0, base2);
        rd_expect("R7 new burst last", BL - 1, base2 + BL - 1);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 0;
        tick();
        t_reset();
        t_decim();
        t_overflow();
        t_burst();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule